// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Word

This block is the arithmetic core of a small accumulator machine. It holds the accumulator, the auxiliary B register and the 8-bit status word. On each cycle where an operation is issued, it performs addition, addition with carry, subtraction with borrow, an 8x8 multiply or an 8/8 divide. It then updates the carry, half-carry and overflow flags by rules that depend on the operation.

The status word also carries two general-purpose software flags and a two-bit register bank selector. A parity bit in the status word always reflects the accumulator. The block maps a 3-bit working-register index through the current bank selector to a 5-bit register-file address. Software can load the accumulator, B and the status word directly. Within a single cycle, a direct load overrides the arithmetic result for the same register.

Top module: `acc_alu_psw`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, B, every status word bit and `reg_addr` become 0.
- R2: With `op_valid` high, `op_code` 0 (add) writes A+operand to A and `op_code` 1 (add with carry) writes A+operand+CY to A. CY becomes the carry out of bit 7. Codes 5 to 7 change nothing.
- R3: After add and add with carry, AC is the carry out of bit 3. After subtract, AC is the borrow into bit 3. In both cases the incoming carry or borrow is included. Multiply and divide clear AC.
- R4: After the add, add with carry and subtract operations, OV is 1 exactly when the two's-complement result falls outside -128..127.
- R5: `op_code` 2 (subtract with borrow) writes A-operand-CY to A. CY becomes 1 when that difference is negative.
- R6: `op_code` 3 (multiply) writes the low byte of A*B to A and the high byte to B. It clears CY and sets OV exactly when the product exceeds 255.
- R7: `op_code` 4 (divide) writes the quotient of A/B to A and the remainder to B, with OV cleared. If B is 0, A and B keep their values and OV is set. CY is cleared in both cases.
- R8: Status bit 0 is 1 when the accumulator holds an odd number of ones, including right after a direct accumulator load. Software cannot write it.
- R9: `reg_addr` is registered. After each edge it equals bank*8 + `reg_idx`, where bank is status bits [4:3] before that edge.
- R10: Status bits 5 and 1 (software flags) and bits [4:3] (bank) change only through a status word write. Arithmetic leaves them unchanged.
- R11: A status word write loads bits 7..1 from `psw_wr_data`, overriding a same-cycle flag update. Direct A and B loads likewise override same-cycle arithmetic results. Status bits are CY=7, AC=6, OV=2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue an arithmetic operation this cycle |
| op_code | input | 3 | Operation: 0 add, 1 add with carry, 2 subtract with borrow, 3 multiply, 4 divide |
| operand | input | 8 | Second operand for add and subtract |
| acc_wr_en | input | 1 | Direct accumulator load |
| acc_wr_data | input | 8 | Accumulator load value |
| b_wr_en | input | 1 | Direct B load |
| b_wr_data | input | 8 | B load value |
| psw_wr_en | input | 1 | Status word write |
| psw_wr_data | input | 8 | Status word write value (bit 0 ignored) |
| reg_idx | input | 3 | Working register index to map |
| acc_q | output | 8 | Accumulator |
| b_q | output | 8 | B register |
| psw_q | output | 8 | Status word {CY, AC, F0, RS1, RS0, OV, F1, P} |
| reg_addr | output | 5 | Registered register-file address |

## Verification
The properties assume that every control input is a defined 0 or 1 at each clock edge. They also assume that `rst` is asserted from the first edge, so that the reset checks find a known starting state. The divide-by-zero property only applies when neither A nor B is being loaded directly in that cycle. The bench drives all inputs just after the falling edge with fully defined values and holds reset for several cycles at start. It mixes directed corner operands with random cycles in which direct loads sometimes coincide with arithmetic. Those collision cycles are excluded by the antecedents of the properties that would otherwise need them.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUBB = 3'd2,
    OP_MUL  = 3'd3,
    OP_DIV  = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } arith_flags_t;

  // status word bit positions
  localparam int SW_CY  = 7;
  localparam int SW_AC  = 6;
  localparam int SW_F0  = 5;
  localparam int SW_RSH = 4;
  localparam int SW_RSL = 3;
  localparam int SW_OV  = 2;
  localparam int SW_F1  = 1;
  localparam int SW_PAR = 0;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          sub_i,
  input  logic          cin_i,
  output logic [W-1:0]  res_o,
  output arith_flags_t  flg_o
);
  localparam int HW = W / 2;

  logic [W:0]  full;
  logic [HW:0] half;
  logic [W:0]  cin_w;
  logic [HW:0] cin_h;

  assign cin_w = {{W{1'b0}}, cin_i};
  assign cin_h = {{HW{1'b0}}, cin_i};

  always_comb begin
    if (sub_i) begin
      full = {1'b0, a_i} - {1'b0, b_i} - cin_w;
      half = {1'b0, a_i[HW-1:0]} - {1'b0, b_i[HW-1:0]} - cin_h;
    end else begin
      full = {1'b0, a_i} + {1'b0, b_i} + cin_w;
      half = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]} + cin_h;
    end
    res_o    = full[W-1:0];
    flg_o.cy = full[W];
    flg_o.ac = half[HW];
    if (sub_i)
      flg_o.ov = (a_i[W-1] != b_i[W-1]) && (full[W-1] != a_i[W-1]);
    else
      flg_o.ov = (a_i[W-1] == b_i[W-1]) && (full[W-1] != a_i[W-1]);
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] prod_lo_o,
  output logic [W-1:0] prod_hi_o,
  output logic         prod_big_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         div_zero_o
);
  logic [2*W-1:0] prod;

  assign prod       = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
  assign prod_lo_o  = prod[W-1:0];
  assign prod_hi_o  = prod[2*W-1:W];
  assign prod_big_o = |prod[2*W-1:W];
  assign div_zero_o = (b_i == '0);

  always_comb begin
    if (div_zero_o) begin
      quot_o = '0;
      rem_o  = '0;
    end else begin
      quot_o = a_i / b_i;
      rem_o  = a_i % b_i;
    end
  end
endmodule

// File: rtl/acc_alu_bankmap.sv
module acc_alu_bankmap #(
  parameter int BANK_W = 2,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [BANK_W-1:0]       bank_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic [BANK_W+IDX_W-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (rst) addr_o <= '0;
    else     addr_o <= {bank_i, idx_i};
  end
endmodule

// File: rtl/acc_alu_psw.sv
module acc_alu_psw
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    op_valid,
  input  logic [2:0]              op_code,
  input  logic [DATA_W-1:0]       operand,
  input  logic                    acc_wr_en,
  input  logic [DATA_W-1:0]       acc_wr_data,
  input  logic                    b_wr_en,
  input  logic [DATA_W-1:0]       b_wr_data,
  input  logic                    psw_wr_en,
  input  logic [7:0]              psw_wr_data,
  input  logic [IDX_W-1:0]        reg_idx,
  output logic [DATA_W-1:0]       acc_q,
  output logic [DATA_W-1:0]       b_q,
  output logic [7:0]              psw_q,
  output logic [IDX_W+1:0]        reg_addr
);
  localparam int BANK_W = 2;

  alu_op_e             op;
  logic [DATA_W-1:0]   acc_r, b_r;
  logic                cy_r, ac_r, f0_r, ov_r, f1_r;
  logic [BANK_W-1:0]   rs_r;

  logic [DATA_W-1:0]   as_res;
  arith_flags_t        as_flg;
  logic [DATA_W-1:0]   p_lo, p_hi, d_q, d_r;
  logic                p_big, d_zero;

  assign op = alu_op_e'(op_code);

  acc_alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i   (acc_r),
    .b_i   (operand),
    .sub_i (op == OP_SUBB),
    .cin_i ((op == OP_ADD) ? 1'b0 : cy_r),
    .res_o (as_res),
    .flg_o (as_flg)
  );

  acc_alu_muldiv #(.W(DATA_W)) u_muldiv (
    .a_i        (acc_r),
    .b_i        (b_r),
    .prod_lo_o  (p_lo),
    .prod_hi_o  (p_hi),
    .prod_big_o (p_big),
    .quot_o     (d_q),
    .rem_o      (d_r),
    .div_zero_o (d_zero)
  );

  acc_alu_bankmap #(.BANK_W(BANK_W), .IDX_W(IDX_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .bank_i (rs_r),
    .idx_i  (reg_idx),
    .addr_o (reg_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_r <= '0;
      b_r   <= '0;
      cy_r  <= 1'b0;
      ac_r  <= 1'b0;
      f0_r  <= 1'b0;
      rs_r  <= '0;
      ov_r  <= 1'b0;
      f1_r  <= 1'b0;
    end else begin
      if (op_valid) begin
        case (op)
          OP_ADD, OP_ADDC, OP_SUBB: begin
            acc_r <= as_res;
            cy_r  <= as_flg.cy;
            ac_r  <= as_flg.ac;
            ov_r  <= as_flg.ov;
          end
          OP_MUL: begin
            acc_r <= p_lo;
            b_r   <= p_hi;
            cy_r  <= 1'b0;
            ac_r  <= 1'b0;
            ov_r  <= p_big;
          end
          OP_DIV: begin
            cy_r <= 1'b0;
            ac_r <= 1'b0;
            ov_r <= d_zero;
            if (!d_zero) begin
              acc_r <= d_q;
              b_r   <= d_r;
            end
          end
          default: ;
        endcase
      end
      // direct loads take precedence over results of the same cycle
      if (acc_wr_en) acc_r <= acc_wr_data;
      if (b_wr_en)   b_r   <= b_wr_data;
      if (psw_wr_en) begin
        cy_r <= psw_wr_data[SW_CY];
        ac_r <= psw_wr_data[SW_AC];
        f0_r <= psw_wr_data[SW_F0];
        rs_r <= psw_wr_data[SW_RSH:SW_RSL];
        ov_r <= psw_wr_data[SW_OV];
        f1_r <= psw_wr_data[SW_F1];
      end
    end
  end

  assign acc_q = acc_r;
  assign b_q   = b_r;
  assign psw_q = {cy_r, ac_r, f0_r, rs_r, ov_r, f1_r, ^acc_r};
endmodule

// File: rtl/acc_alu_psw_chk.sv
module acc_alu_psw_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic              acc_wr_en,
  input logic [DATA_W-1:0] acc_wr_data,
  input logic              b_wr_en,
  input logic              psw_wr_en,
  input logic [7:0]        psw_wr_data,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [DATA_W-1:0] acc_q,
  input logic [DATA_W-1:0] b_q,
  input logic [7:0]        psw_q,
  input logic [IDX_W+1:0]  reg_addr
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && b_q == '0 && psw_q == 8'h00 && reg_addr == '0));

  p_mul_flags_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_MUL && !psw_wr_en) |=> (!psw_q[SW_CY] && !psw_q[SW_AC]));

  p_div_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_DIV && b_q == '0 && !psw_wr_en && !acc_wr_en && !b_wr_en)
    |=> (psw_q[SW_OV] && !psw_q[SW_CY] && $stable(acc_q) && $stable(b_q)));

  p_parity_load_r8: assert property (@(posedge clk) disable iff (rst)
    acc_wr_en |=> (psw_q[SW_PAR] == ^$past(acc_wr_data)));

  p_bank_addr_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (reg_addr == {$past(psw_q[SW_RSH:SW_RSL]), $past(reg_idx)}));

  p_user_flags_r10: assert property (@(posedge clk) disable iff (rst)
    !psw_wr_en |=> ($stable(psw_q[SW_F0]) && $stable(psw_q[SW_F1]) && $stable(psw_q[SW_RSH:SW_RSL])));

  p_sw_write_r11: assert property (@(posedge clk) disable iff (rst)
    psw_wr_en |=> (psw_q[7:1] == $past(psw_wr_data[7:1])));
endmodule

bind acc_alu_psw acc_alu_psw_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_valid    (op_valid),
  .op_code     (op_code),
  .acc_wr_en   (acc_wr_en),
  .acc_wr_data (acc_wr_data),
  .b_wr_en     (b_wr_en),
  .psw_wr_en   (psw_wr_en),
  .psw_wr_data (psw_wr_data),
  .reg_idx     (reg_idx),
  .acc_q       (acc_q),
  .b_q         (b_q),
  .psw_q       (psw_q),
  .reg_addr    (reg_addr)
);

// File: tb/tb_acc_alu_psw.sv
`timescale 1ns/1ps
module tb_acc_alu_psw;
  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [2:0] op_code;
  logic [7:0] operand;
  logic       acc_wr_en;
  logic [7:0] acc_wr_data;
  logic       b_wr_en;
  logic [7:0] b_wr_data;
  logic       psw_wr_en;
  logic [7:0] psw_wr_data;
  logic [2:0] reg_idx;
  logic [7:0] acc_q, b_q, psw_q;
  logic [4:0] reg_addr;

  acc_alu_psw dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .operand(operand),
    .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data), .b_wr_en(b_wr_en), .b_wr_data(b_wr_data),
    .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data), .reg_idx(reg_idx),
    .acc_q(acc_q), .b_q(b_q), .psw_q(psw_q), .reg_addr(reg_addr)
  );

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  int m_a, m_b, m_cy, m_ac, m_f0, m_rs, m_ov, m_f1, m_addr;
  string t_a, t_b, t_cy, t_ac, t_ov, t_spare;

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int odd_ones(int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return c & 1;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(t_a, "acc", int'(acc_q), m_a);
    check(t_b, "b", int'(b_q), m_b);
    check(t_cy, "CY", int'(psw_q[7]), m_cy);
    check(t_ac, "AC", int'(psw_q[6]), m_ac);
    check(t_spare, "F0", int'(psw_q[5]), m_f0);
    check(t_spare, "bank", int'(psw_q[4:3]), m_rs);
    check(t_ov, "OV", int'(psw_q[2]), m_ov);
    check(t_spare, "F1", int'(psw_q[1]), m_f1);
    check("R8", "parity", int'(psw_q[0]), odd_ones(m_a));
    check("R9", "reg_addr", int'(reg_addr), m_addr);
  endtask

  // one clock of stimulus: drive after negedge, model, compare at next negedge
  task automatic step(bit v, int op, int opd, bit aw, int ad, bit bw, int bd,
                      bit pw, int pd, int idx);
    int na, nb, ncy, nac, nov, s, cin, r;
    op_valid = v; op_code = op[2:0]; operand = opd[7:0];
    acc_wr_en = aw; acc_wr_data = ad[7:0];
    b_wr_en = bw; b_wr_data = bd[7:0];
    psw_wr_en = pw; psw_wr_data = pd[7:0];
    reg_idx = idx[2:0];
    na = m_a; nb = m_b; ncy = m_cy; nac = m_ac; nov = m_ov;
    t_a = "R2"; t_b = "R6"; t_cy = "R2"; t_ac = "R3"; t_ov = "R4"; t_spare = "R10";
    if (v) begin
      case (op)
        0, 1: begin
          cin = (op == 1) ? m_cy : 0;
          s = m_a + (opd & 255) + cin;
          na = s & 255; ncy = (s > 255);
          nac = (((m_a & 15) + (opd & 15) + cin) > 15);
          r = sx(m_a) + sx(opd & 255) + cin;
          nov = (r > 127 || r < -128);
        end
        2: begin
          s = m_a - (opd & 255) - m_cy;
          na = s & 255; ncy = (s < 0);
          nac = (((m_a & 15) - (opd & 15) - m_cy) < 0);
          r = sx(m_a) - sx(opd & 255) - m_cy;
          nov = (r > 127 || r < -128);
          t_a = "R5"; t_cy = "R5";
        end
        3: begin
          s = m_a * m_b;
          na = s & 255; nb = s >> 8; ncy = 0; nac = 0; nov = (s > 255);
          t_a = "R6"; t_cy = "R6"; t_ov = "R6"; t_ac = "R3";
        end
        4: begin
          ncy = 0; nac = 0;
          if (m_b == 0) nov = 1;
          else begin na = m_a / m_b; nb = m_a % m_b; nov = 0; end
          t_a = "R7"; t_b = "R7"; t_cy = "R7"; t_ov = "R7";
        end
        default: begin t_a = "R2"; t_cy = "R2"; end
      endcase
    end
    if (aw) begin na = ad & 255; t_a = "R11"; end
    if (bw) begin nb = bd & 255; t_b = "R11"; end
    m_addr = m_rs * 8 + (idx & 7);
    if (pw) begin
      ncy = (pd >> 7) & 1; nac = (pd >> 6) & 1; m_f0 = (pd >> 5) & 1;
      m_rs = (pd >> 3) & 3; nov = (pd >> 2) & 1; m_f1 = (pd >> 1) & 1;
      t_cy = "R11"; t_ac = "R11"; t_ov = "R11"; t_spare = "R11";
    end
    m_a = na; m_b = nb; m_cy = ncy; m_ac = nac; m_ov = nov;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    rst = 1'b1; op_valid = 0; op_code = 0; operand = 0; acc_wr_en = 0; acc_wr_data = 0;
    b_wr_en = 0; b_wr_data = 0; psw_wr_en = 0; psw_wr_data = 0; reg_idx = 0;
    m_a = 0; m_b = 0; m_cy = 0; m_ac = 0; m_f0 = 0; m_rs = 0; m_ov = 0; m_f1 = 0; m_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_a = "R1"; t_b = "R1"; t_cy = "R1"; t_ac = "R1"; t_ov = "R1"; t_spare = "R1";
    compare_all();
    rst = 1'b0;
    // R2/R3/R4: 0x7F + 1 -> 0x80, half carry and signed overflow
    step(0, 0, 0, 1, 8'h7F, 0, 0, 0, 0, 0);
    step(1, 0, 8'h01, 0, 0, 0, 0, 0, 0, 1);
    // R2: 0x80 + 0x80 carries out
    step(1, 0, 8'h80, 0, 0, 0, 0, 0, 0, 2);
    // R2: add with carry uses CY
    step(1, 1, 8'h0F, 0, 0, 0, 0, 0, 0, 3);
    // R5: subtract below zero, borrow
    step(0, 0, 0, 1, 8'h00, 0, 0, 0, 0, 4);
    step(1, 2, 8'h01, 0, 0, 0, 0, 0, 0, 5);
    // R5: subtract with pending borrow, signed overflow 0x80-0x00-1
    step(0, 0, 0, 1, 8'h80, 0, 0, 8'h80, 0, 6);
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h80, 7);
    step(1, 2, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    // R6: 0x10 * 0x10 = 0x0100
    step(0, 0, 0, 1, 8'h10, 1, 8'h10, 0, 0, 0);
    step(1, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 8'h0C, 1, 8'h0B, 0, 0, 0);
    step(1, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7: divide by zero leaves A/B, then 200 / 7
    step(0, 0, 0, 1, 8'hC8, 1, 8'h00, 0, 0, 0);
    step(1, 4, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 8'h07, 0, 0, 0);
    step(1, 4, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9/R10: bank 2, flags set, then arithmetic leaves them
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h32, 5);
    step(1, 0, 8'h33, 0, 0, 0, 0, 0, 0, 5);
    step(1, 0, 8'h01, 0, 0, 0, 0, 0, 0, 7);
    // R11: write collides with add; status write and acc load win; P read-only
    step(1, 0, 8'hFF, 1, 8'h07, 0, 0, 1, 8'hFF, 2);
    step(1, 7, 8'h55, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h00, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 10) < 7, $urandom % 8, $urandom % 256,
           ($urandom % 10) == 0, $urandom % 256,
           ($urandom % 10) == 0, $urandom % 256,
           ($urandom % 12) == 0, $urandom % 256, $urandom % 8);
    end
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule